// File: doc/BRIEF.md
# Noise Sound Channel

This block produces the pseudo-random noise voice of a sound unit. A 15-bit linear feedback shift register advances at a programmable rate. Its lowest bit gates a 4-bit envelope volume onto the amplitude output. The shift register can run either the full-length sequence or a shortened one, which gives a more tonal, metallic noise.

Software programs the block with byte writes on a small register bus. The writes set the volume envelope, the clocking of the shift register, the play length and the length enable. A write of the control byte with its top bit set starts or restarts the sound. Two slow tick inputs come from a frame sequencer. The length tick (nominally 256 Hz) drives a length countdown. The envelope tick (nominally 64 Hz) drives the volume ramp. The block reports the current amplitude and whether the channel is still sounding.

The step rate is counted in cycles of `clk_i`, which plays the role of the sound unit's master clock.

Top module: `noise_channel`

## Requirements
- R1: After reset, `amp_o` is 0 and `active_o` is 0.
- R2: A write with `wr_addr_i` 0 takes the length value from data bits 5:0. Address 1 takes the envelope: bits 7:4 initial volume, bit 3 direction (1 up, 0 down), bits 2:0 period. Address 2 takes the clocking: bits 7:4 shift exponent, bit 3 short mode, bits 2:0 divisor code. Address 3 is control: bit 6 length enable, bit 7 trigger.
- R3: A trigger sets the shift register to all ones, reloads the volume from the initial value, restarts the step divider and the envelope timer, and sets `active_o`. Immediately after a trigger `amp_o` is 0.
- R4: While the channel is active, the shift register steps once every P clock cycles, with P = B << shift. B is 4 for divisor code 0 and 8 times the code otherwise. The first step comes P cycles after the trigger.
- R5: On each step the register shifts toward bit 0, and bit 0 XOR bit 1 enters bit 14.
- R6: In short mode that same feedback bit is also written into bit 6.
- R7: `amp_o` equals the envelope volume when the channel is active and shift register bit 0 is 0, and equals 0 otherwise.
- R8: With a nonzero envelope period N, every N-th envelope tick moves the volume by one in the programmed direction. The volume saturates at 15 and at 0.
- R9: With an envelope period of 0, envelope ticks leave the volume unchanged.
- R10: A length write loads a countdown with 64 minus the length value. When length is enabled, each length tick decrements a nonzero countdown. Reaching zero clears `active_o`. A trigger with the countdown at zero reloads it with 64.
- R11: With length disabled, length ticks do not change `active_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 8 | Register write data |
| len_tick_i | input | 1 | Length countdown tick, one cycle wide |
| env_tick_i | input | 1 | Envelope tick, one cycle wide |
| amp_o | output | 4 | Current channel amplitude |
| active_o | output | 1 | Channel sounding flag |

## Verification
The noise sequence is tried with six clocking settings. They mix long and short modes, divisor codes 0 to 3 and shift exponents 0 and 1. For each setting, the amplitude is compared one cycle before and exactly at each of twenty steps. The long and short sequences are told apart by where the first nonzero amplitude appears, and a wrong step period shows up as a change one cycle early or late. The envelope runs up, down and at a period of 0 and 2, including both saturation limits. The length countdown is tried with enable on and off and with the shortest nonzero count.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int LFSR_W    = 15;
  localparam int SHORT_TAP = 6;
  localparam int VOL_W     = 4;
  localparam int LEN_W     = 6;
  localparam int SHIFT_W   = 4;
  localparam int CODE_W    = 3;
  localparam int DIV_W     = 22;

  typedef enum logic [1:0] {
    REG_LEN  = 2'd0,
    REG_ENV  = 2'd1,
    REG_POLY = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/noise_divider.sv
module noise_divider #(
  parameter int DIV_W   = 22,
  parameter int CODE_W  = 3,
  parameter int SHIFT_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               active_i,
  input  logic               trig_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               step_o
);
  logic [DIV_W-1:0] base, period, cnt_q;

  always_comb begin
    base   = (code_i == '0) ? DIV_W'(4) : (DIV_W'(code_i) << 3);
    period = base << shift_i;
  end

  assign step_o = active_i && !trig_i && (cnt_q >= period - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (trig_i)   cnt_q <= '0;
    else if (step_o)   cnt_q <= '0;
    else if (active_i) cnt_q <= cnt_q + DIV_W'(1);
  end

  // minimum period is 4, so steps never come back to back
  a_r4_step_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int W   = 15,
  parameter int TAP = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic step_i,
  input  logic short_i,
  output logic bit0_o
);
  logic [W-1:0] state_q, shifted;
  logic         fb;

  assign fb = state_q[0] ^ state_q[1];

  always_comb begin
    shifted = {fb, state_q[W-1:1]};
    if (short_i) shifted[TAP] = fb;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= '1;
    else if (trig_i)  state_q <= '1;
    else if (step_i)  state_q <= shifted;
  end

  assign bit0_o = state_q[0];

  a_r3_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (state_q == '1));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && !step_i) |=> $stable(state_q));
  a_r6_short_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !trig_i && short_i) |=> (state_q[TAP] == state_q[W-1]));
endmodule

// File: rtl/noise_envelope.sv
module noise_envelope #(
  parameter int VOL_W = 4,
  parameter int PER_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic [VOL_W-1:0] init_i,
  input  logic             up_i,
  input  logic [PER_W-1:0] per_i,
  output logic [VOL_W-1:0] vol_o
);
  localparam logic [VOL_W-1:0] VMAX = '1;

  logic [VOL_W-1:0] vol_q;
  logic [PER_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q <= '0;
      tmr_q <= '0;
    end else if (trig_i) begin
      vol_q <= init_i;
      tmr_q <= per_i;
    end else if (tick_i && per_i != '0) begin
      if (tmr_q <= PER_W'(1)) begin
        tmr_q <= per_i;
        if (up_i && vol_q != VMAX)       vol_q <= vol_q + VOL_W'(1);
        else if (!up_i && vol_q != '0)   vol_q <= vol_q - VOL_W'(1);
      end else begin
        tmr_q <= tmr_q - PER_W'(1);
      end
    end
  end

  assign vol_o = vol_q;

  a_r8_sat_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vol_q == VMAX && up_i && !trig_i) |=> (vol_q == VMAX));
  a_r8_sat_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vol_q == '0 && !up_i && !trig_i) |=> (vol_q == '0));
  a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_i == '0 && !trig_i) |=> $stable(vol_q));
endmodule

// File: rtl/noise_length.sv
module noise_length #(
  parameter int LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             trig_i,
  input  logic             en_i,
  input  logic             tick_i,
  output logic             expire_o
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << LEN_W;

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && en_i && !load_i && !trig_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (load_i)                         cnt_q <= FULL - CNT_W'(len_i);
    else if (trig_i && cnt_q == '0)          cnt_q <= FULL;
    else if (!trig_i && tick_i && en_i && cnt_q != '0)
                                             cnt_q <= cnt_q - CNT_W'(1);
  end

  a_r10_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && cnt_q != '0 && !load_i && !trig_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i && !trig_i) |=> $stable(cnt_q));
endmodule

// File: rtl/noise_channel.sv
module noise_channel
  import noise_pkg::*;
#(
  parameter int AMP_W = VOL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             len_tick_i,
  input  logic             env_tick_i,
  output logic [AMP_W-1:0] amp_o,
  output logic             active_o
);
  logic wr_len, wr_env, wr_poly, wr_ctrl, trig;

  logic [VOL_W-1:0]   init_vol_q;
  logic               env_up_q;
  logic [2:0]         env_per_q;
  logic [SHIFT_W-1:0] shift_q;
  logic               short_q;
  logic [CODE_W-1:0]  code_q;
  logic               len_en_q;
  logic               active_q;

  logic step, bit0, expire;
  logic [VOL_W-1:0] vol;

  assign wr_len  = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_LEN);
  assign wr_env  = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_ENV);
  assign wr_poly = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_POLY);
  assign wr_ctrl = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_CTRL);
  assign trig    = wr_ctrl && wr_data_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_vol_q <= '0;
      env_up_q   <= 1'b0;
      env_per_q  <= '0;
      shift_q    <= '0;
      short_q    <= 1'b0;
      code_q     <= '0;
      len_en_q   <= 1'b0;
    end else begin
      if (wr_env) begin
        init_vol_q <= wr_data_i[7:4];
        env_up_q   <= wr_data_i[3];
        env_per_q  <= wr_data_i[2:0];
      end
      if (wr_poly) begin
        shift_q <= wr_data_i[7:4];
        short_q <= wr_data_i[3];
        code_q  <= wr_data_i[2:0];
      end
      if (wr_ctrl) len_en_q <= wr_data_i[6];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= 1'b0;
    else if (trig)   active_q <= 1'b1;
    else if (expire) active_q <= 1'b0;
  end

  noise_divider #(.DIV_W(DIV_W), .CODE_W(CODE_W), .SHIFT_W(SHIFT_W)) u_div (
    .clk_i, .rst_ni, .active_i(active_q), .trig_i(trig),
    .code_i(code_q), .shift_i(shift_q), .step_o(step)
  );

  noise_lfsr #(.W(LFSR_W), .TAP(SHORT_TAP)) u_lfsr (
    .clk_i, .rst_ni, .trig_i(trig), .step_i(step),
    .short_i(short_q), .bit0_o(bit0)
  );

  noise_envelope #(.VOL_W(VOL_W), .PER_W(3)) u_env (
    .clk_i, .rst_ni, .trig_i(trig), .tick_i(env_tick_i),
    .init_i(init_vol_q), .up_i(env_up_q), .per_i(env_per_q), .vol_o(vol)
  );

  noise_length #(.LEN_W(LEN_W)) u_len (
    .clk_i, .rst_ni, .load_i(wr_len), .len_i(wr_data_i[LEN_W-1:0]),
    .trig_i(trig), .en_i(len_en_q), .tick_i(len_tick_i), .expire_o(expire)
  );

  assign amp_o    = (active_q && !bit0) ? AMP_W'(vol) : '0;
  assign active_o = active_q;

  a_r3_active_on_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> active_o);
  a_r3_silent_after_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> (amp_o == '0));
  a_r10_expire_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> !active_o);
endmodule

// File: tb/noise_channel_test.sv
module noise_channel_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic       len_tick = 0;
  logic       env_tick = 0;
  logic [3:0] amp;
  logic       active;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  noise_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .len_tick_i(len_tick), .env_tick_i(env_tick),
    .amp_o(amp), .active_o(active)
  );

  // {clocking byte, envelope byte}
  localparam logic [15:0] VEC [6] = '{
    16'h00_F0, 16'h08_A0, 16'h10_70, 16'h19_50, 16'h03_C0, 16'h0A_30
  };
  localparam int STEPS = 20;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic env_pulse();
    @(negedge clk); env_tick = 1;
    @(posedge clk);
    @(negedge clk); env_tick = 0;
  endtask

  task automatic len_pulse();
    @(negedge clk); len_tick = 1;
    @(posedge clk);
    @(negedge clk); len_tick = 0;
  endtask

  function automatic logic [14:0] nxt(input logic [14:0] s, input logic sh);
    logic fb;
    logic [14:0] r;
    fb = s[0] ^ s[1];
    r = {fb, s[14:1]};
    if (sh) r[6] = fb;
    return r;
  endfunction

  function automatic int period_of(input logic [7:0] p);
    int b;
    b = (p[2:0] == 0) ? 4 : 8 * p[2:0];
    return b << p[7:4];
  endfunction

  // trigger fast long-mode run, wait 15 steps (bit 0 is then 0), then freeze stepping
  task automatic prime(input logic [7:0] env, input logic [7:0] ctrl);
    wr(2, 8'h00);
    wr(1, env);
    wr(3, ctrl);
    repeat (60) @(posedge clk);
    wr(2, 8'hF0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(amp, 0, "R1 amp");
    check(active, 0, "R1 active");
    rst_n = 1;
    @(negedge clk);
    check(amp, 0, "R1 amp after release");

    // noise sequence vectors: R2 R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      logic [7:0]  p, e;
      logic [14:0] s;
      int          per;
      p = VEC[v][15:8];
      e = VEC[v][7:0];
      per = period_of(p);
      s = '1;
      wr(2, p);
      wr(1, e);
      wr(3, 8'h80);
      check(active, 1, "R3 active");
      for (int k = 1; k <= STEPS; k++) begin
        repeat (per - 1) @(posedge clk);
        @(negedge clk);
        check(amp, s[0] ? 8'd0 : 8'(e[7:4]), k == 1 ? "R3 amp before step" : "R4 amp held");
        s = nxt(s, p[3]);
        @(posedge clk);
        @(negedge clk);
        check(amp, s[0] ? 8'd0 : 8'(e[7:4]), p[3] ? "R6 short step" : "R5 long step");
      end
    end

    // R7 volume reaches output once bit 0 is 0
    prime(8'hD9, 8'h80);
    check(amp, 13, "R7 amp");
    // R8 up with saturation
    env_pulse(); check(amp, 14, "R8 up");
    env_pulse(); check(amp, 15, "R8 up");
    env_pulse(); check(amp, 15, "R8 saturate 15");
    // R8 down with saturation
    prime(8'h21, 8'h80);
    env_pulse(); check(amp, 1, "R8 down");
    env_pulse(); check(amp, 0, "R8 down");
    env_pulse(); check(amp, 0, "R8 saturate 0");
    // R9 period 0 frozen
    prime(8'h90, 8'h80);
    env_pulse(); check(amp, 9, "R9 frozen");
    env_pulse(); check(amp, 9, "R9 frozen");
    // R8 period 2
    prime(8'h4A, 8'h80);
    env_pulse(); check(amp, 4, "R8 period2 wait");
    env_pulse(); check(amp, 5, "R8 period2 step");
    env_pulse(); check(amp, 5, "R8 period2 wait");
    env_pulse(); check(amp, 6, "R8 period2 step");

    // R10 length 62 -> two ticks
    wr(0, 8'd62);
    prime(8'hB0, 8'hC0);
    check(amp, 11, "R10 sounding");
    len_pulse(); check(active, 1, "R10 first tick");
    check(amp, 11, "R10 first tick amp");
    len_pulse(); check(active, 0, "R10 expired");
    check(amp, 0, "R10 silent");
    // R11 length disabled
    prime(8'hB0, 8'h80);
    len_pulse(); len_pulse(); len_pulse();
    check(active, 1, "R11 disabled active");
    check(amp, 11, "R11 disabled amp");
    // R10 length 63 -> one tick
    wr(0, 8'd63);
    prime(8'hB0, 8'hC0);
    len_pulse(); check(active, 0, "R10 length 63");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule